// File: doc/BRIEF.md
# Two-Slot Signal Handoff

This block hands single data items from a producer to a consumer that issue their requests independently of each other. Storage is two one-item slots. Coordination is two one-bit control variables: a write index `w` owned by the producer and a read index `r` owned by the consumer. The producer is never held back, and it may replace an item that nobody has taken yet. The consumer only ever takes an item it has not seen before. When nothing new exists, its request waits.

Both sides share one clock, and either side may raise a request in any cycle. A write stores its item into the slot selected by `w`. It then sets `w` to the complement of `r`. A read first complements `r`. It then stays pending until `w` and `r` differ, and only then returns the slot selected by `r`. When both sides update in the same cycle, the consumer's flip of `r` takes effect first, and the producer sees the new value. The handoff holds at most one item, and at times none: a read issued straight after a single write from reset still has to wait for a second write.

Top module: `sig2_acm`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_done` and `rd_valid` are low and `rd_data` is zero. Reset clears both control bits and both slots.
- R2: A write request is accepted in every cycle in which `wr_req` is high, with no stall. `wr_done` is high in exactly the cycle after each accepted write and low in every other cycle.
- R3: A write stores `wr_data` into the slot selected by `w` and then sets `w` to the complement of `r`. When a read starts in the same cycle, `w` takes the complement of the already flipped `r`, so that read can complete without waiting for another write.
- R4: A read starts when `rd_req` is high and no read is pending. Starting a read flips `r`. A pending read completes only once `w` differs from `r`. From reset, one write followed by a read leaves that read waiting.
- R5: No read completes before the first write since reset. A read that is already pending when the first write arrives completes two cycles after that write, carrying the cleared slot value zero.
- R6: A read completes with `rd_valid` high for exactly one cycle: the cycle after the clock edge at which `w` differed from `r`. In that cycle `rd_data` equals the slot that `r` selects. `rd_data` keeps that value until the next completion.
- R7: Writes overwrite one another freely. From reset, if item X is written, a read starts, and item Y is written, the read returns Y and X is never delivered.
- R8: No item is delivered twice. After a completion, the next read stays pending until a further write.
- R9: `rd_req` is held high until `rd_valid` is seen. If `rd_req` is still high in the cycle `rd_valid` is high, a new read starts at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Producer writes `wr_data` in this cycle |
| wr_data | input | DATA_W | Item to be written |
| wr_done | output | 1 | Pulse one cycle after each accepted write |
| rd_req | input | 1 | Consumer requests a new item; held until `rd_valid` |
| rd_data | output | DATA_W | Item delivered by the last completed read |
| rd_valid | output | 1 | One-cycle pulse marking a completed read |

## Verification
`wr_done` is due one cycle after the write edge. A completion is decided from the registered `w` and `r`, so `rd_valid` and `rd_data` appear one cycle after the edge at which the indices differ. For a read waiting on a write, that is two cycles after the write. The bench drives inputs on the falling edge. At each rising edge it advances its own model of the slots, the indices and the pending read. It then compares the outputs at the following falling edge, which is exactly where each registered result is due. Directed sequences pin down the cases that depend on exact cycles: waiting after a single write, a read pending before any write, and a write that coincides with a read start.

// File: rtl/sig2_pkg.sv
package sig2_pkg;

    // Consumer-side phase: no read outstanding, or read waiting for fresh data
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_e;

    // The handoff is defined for exactly two slots addressed by one bit
    localparam int unsigned NUM_SLOTS = 2;
    localparam int unsigned IDX_W     = $clog2(NUM_SLOTS);

endpackage

// File: rtl/sig2_slots.sv
module sig2_slots
    import sig2_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot_q [NUM_SLOTS];
    logic [DATA_W-1:0] slot_d [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_comb begin
            slot_d[s] = slot_q[s];
            if (we && (widx == IDX_W'(s))) begin
                slot_d[s] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '0;
            end else begin
                slot_q[s] <= slot_d[s];
            end
        end
    end

    assign rdata = slot_q[ridx];

endmodule

// File: rtl/sig2_writer.sv
module sig2_writer
    import sig2_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [IDX_W-1:0] r_next,
    output logic [IDX_W-1:0] w_q,
    output logic             slot_we,
    output logic [IDX_W-1:0] slot_widx,
    output logic             wr_done,
    output logic             wrote_q
);

    typedef struct packed {
        logic [IDX_W-1:0] w;
        logic             done;
        logic             wrote;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = wr_req;
        if (wr_req) begin
            // the store goes to the current w; the index then points away from the reader
            st_d.w     = ~r_next;
            st_d.wrote = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign w_q       = st_q.w;
    assign slot_we   = wr_req;
    assign slot_widx = st_q.w;
    assign wr_done   = st_q.done;
    assign wrote_q   = st_q.wrote;

endmodule

// File: rtl/sig2_reader.sv
module sig2_reader
    import sig2_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [IDX_W-1:0]  w_q,
    input  logic              wrote_q,
    input  logic [DATA_W-1:0] slot_rdata,
    output logic [IDX_W-1:0]  r_q,
    output logic [IDX_W-1:0]  r_next,
    output logic [IDX_W-1:0]  slot_ridx,
    output logic              rd_busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        rd_state_e         state;
        logic [IDX_W-1:0]  r;
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        unique case (st_q.state)
            RD_IDLE: begin
                if (rd_req) begin
                    st_d.r     = ~st_q.r;
                    st_d.state = RD_WAIT;
                end
            end
            RD_WAIT: begin
                if (wrote_q && (w_q != st_q.r)) begin
                    st_d.valid = 1'b1;
                    st_d.data  = slot_rdata;
                    st_d.state = RD_IDLE;
                end
            end
            default: st_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign r_q       = st_q.r;
    assign r_next    = st_d.r;
    assign slot_ridx = st_q.r;
    assign rd_busy   = (st_q.state == RD_WAIT);
    assign rd_valid  = st_q.valid;
    assign rd_data   = st_q.data;

endmodule

// File: rtl/sig2_acm.sv
module sig2_acm
    import sig2_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_done,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [IDX_W-1:0]  w_q;
    logic [IDX_W-1:0]  r_q;
    logic [IDX_W-1:0]  r_next;
    logic [IDX_W-1:0]  slot_widx;
    logic [IDX_W-1:0]  slot_ridx;
    logic              slot_we;
    logic              wrote_q;
    logic              rd_busy;
    logic [DATA_W-1:0] slot_rdata;

    sig2_slots #(.DATA_W(DATA_W)) i_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (slot_we),
        .widx  (slot_widx),
        .wdata (wr_data),
        .ridx  (slot_ridx),
        .rdata (slot_rdata)
    );

    sig2_writer i_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .r_next    (r_next),
        .w_q       (w_q),
        .slot_we   (slot_we),
        .slot_widx (slot_widx),
        .wr_done   (wr_done),
        .wrote_q   (wrote_q)
    );

    sig2_reader #(.DATA_W(DATA_W)) i_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .w_q        (w_q),
        .wrote_q    (wrote_q),
        .slot_rdata (slot_rdata),
        .r_q        (r_q),
        .r_next     (r_next),
        .slot_ridx  (slot_ridx),
        .rd_busy    (rd_busy),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/sig2_acm_chk.sv
module sig2_acm_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_req,
    input logic wr_done,
    input logic rd_req,
    input logic rd_valid,
    input logic w_q,
    input logic r_q,
    input logic rd_busy,
    input logic wrote_q
);

    p_done_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_done);

    p_no_done_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !wr_done);

    p_w_points_away_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (w_q != r_q));

    p_start_flips_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_busy && rd_req) |=> (r_q != $past(r_q)));

    p_wait_on_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && (w_q == r_q)) |=> !rd_valid);

    p_no_read_before_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> wrote_q);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_idle_on_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !rd_busy);

endmodule

bind sig2_acm sig2_acm_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_done  (wr_done),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .w_q      (w_q),
    .r_q      (r_q),
    .rd_busy  (rd_busy),
    .wrote_q  (wrote_q)
);

// File: tb/test_sig2_acm.sv
module test_sig2_acm;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_req = 1'b0;
    logic          wr_done;
    logic          rd_valid;
    logic [DW-1:0] rd_data;

    always #2 clk = ~clk;

    sig2_acm #(.DATA_W(DW)) i_sig2_acm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_data  (wr_data),
        .wr_done  (wr_done),
        .rd_req   (rd_req),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // reference state derived from the requirements
    logic          m_w, m_r, m_pend, m_wrote;
    logic [DW-1:0] m_slot [2];
    logic          e_done, e_valid;
    logic [DW-1:0] e_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        m_w = 1'b0; m_r = 1'b0; m_pend = 1'b0; m_wrote = 1'b0;
        m_slot[0] = '0; m_slot[1] = '0;
        e_done = 1'b0; e_valid = 1'b0; e_data = '0;
    endtask

    // one clock: drive at falling edge, update model at rising edge, compare at next falling edge
    task automatic step(input bit wr, input logic [DW-1:0] d, input bit rq, input string tag);
        bit   start, comp;
        logic rn;
        wr_req  = wr;
        wr_data = d;
        rd_req  = rq;
        @(posedge clk);
        start = rq && !m_pend;
        comp  = m_pend && m_wrote && (m_w != m_r);
        e_valid = comp;
        if (comp) e_data = m_slot[m_r];
        rn = start ? ~m_r : m_r;
        if (wr) begin
            m_slot[m_w] = d;
            m_w = ~rn;
            m_wrote = 1'b1;
        end
        m_r = rn;
        m_pend = start ? 1'b1 : (comp ? 1'b0 : m_pend);
        e_done = wr;
        @(negedge clk);
        chk(wr_done == e_done, "R2", "wr_done", DW'(wr_done), DW'(e_done));
        chk(rd_valid == e_valid, tag, "rd_valid", DW'(rd_valid), DW'(e_valid));
        if (e_valid) chk(rd_data == e_data, "R6", "rd_data", rd_data, e_data);
    endtask

    task automatic do_reset();
        wr_req = 1'b0; rd_req = 1'b0; wr_data = '0;
        rst_n = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        chk(wr_done == 1'b0, "R1", "wr_done in reset", DW'(wr_done), '0);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", DW'(rd_valid), '0);
        chk(rd_data == '0, "R1", "rd_data in reset", rd_data, '0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        step(1'b0, '0, 1'b0, "R1");
        chk(rd_data == '0, "R1", "rd_data after reset", rd_data, '0);

        // R4 R7: X, read start, waits; Y arrives, read returns Y
        step(1'b1, 16'h1111, 1'b0, "R2");
        step(1'b0, '0, 1'b1, "R4");
        step(1'b0, '0, 1'b1, "R4");
        step(1'b0, '0, 1'b1, "R4");
        chk(rd_valid == 1'b0, "R4", "read after single write waits", DW'(rd_valid), '0);
        step(1'b1, 16'h2222, 1'b1, "R4");
        step(1'b0, '0, 1'b1, "R7");
        chk(rd_valid && rd_data == 16'h2222, "R7", "overwritten read data", rd_data, 16'h2222);
        // R8: next read waits until a new write
        step(1'b0, '0, 1'b1, "R8");
        step(1'b0, '0, 1'b1, "R8");
        step(1'b0, '0, 1'b1, "R8");
        chk(rd_valid == 1'b0, "R8", "no repeat delivery", DW'(rd_valid), '0);
        step(1'b1, 16'h3333, 1'b1, "R8");
        step(1'b0, '0, 1'b0, "R8");
        chk(rd_valid && rd_data == 16'h3333, "R8", "fresh item after wait", rd_data, 16'h3333);
        step(1'b0, '0, 1'b0, "R6");
        chk(rd_valid == 1'b0 && rd_data == 16'h3333, "R6", "single pulse, data held", rd_data, 16'h3333);

        // R5: read pending before any write
        do_reset();
        step(1'b0, '0, 1'b1, "R5");
        step(1'b0, '0, 1'b1, "R5");
        step(1'b0, '0, 1'b1, "R5");
        chk(rd_valid == 1'b0, "R5", "no completion before first write", DW'(rd_valid), '0);
        step(1'b1, 16'h4444, 1'b1, "R5");
        step(1'b0, '0, 1'b0, "R5");
        chk(rd_valid && rd_data == '0, "R5", "first completion carries cleared slot", rd_data, '0);

        // R3: write and read start in the same cycle
        do_reset();
        step(1'b1, 16'h00AA, 1'b0, "R3");
        step(1'b1, 16'h00BB, 1'b1, "R3");
        step(1'b0, '0, 1'b0, "R3");
        chk(rd_valid && rd_data == 16'h00BB, "R3", "same-cycle ordering", rd_data, 16'h00BB);

        // R9: rd_req kept high through the valid cycle starts a new read
        step(1'b1, 16'h00CC, 1'b1, "R9");
        step(1'b0, '0, 1'b1, "R9");
        step(1'b1, 16'h00DD, 1'b1, "R9");
        step(1'b0, '0, 1'b1, "R9");
        chk(rd_valid && rd_data == 16'h00DD, "R9", "back-to-back read", rd_data, 16'h00DD);

        // random traffic
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            bit wr, rq;
            wr = ($urandom_range(0, 2) == 0);
            rq = m_pend ? 1'b1 : bit'($urandom_range(0, 1));
            step(wr, DW'($urandom), rq, "R6");
        end
        summary();
    end

endmodule